// File: doc/BRIEF.md
# Enclave Save-Frame Pop Sequencer

This block performs one "pop" of a secure-enclave thread's state-save stack. On a start pulse it takes a snapshot of the thread's current frame count, the enclave base, the frame offsets, the frame size in pages, the extended-state save size and the control-flow protection attributes. From these it computes where the frame below the current one lives. It then validates, one page at a time, every page that the frame occupies, the page that holds the general-register area, and, when control-flow protection is active, the page that holds the matching control-flow save slot. Validation goes through an external request/acknowledge port. That port answers each request with pass or fail and a physical page number.

The frame count is lowered, and the physical addresses gathered during the walk are committed, only when every check passes. A zero count, a segment-limit violation, a frame larger than the internal slot depth, or any failed page check ends the operation at once. It reports a general-protection or page-fault code and leaves all committed state as it was. A surrounding controller drives `start_i` and waits for the one-cycle `done_o`. On success it writes the `cssa_new_o` value back to its copy of the counter when `cssa_we_o` is high.

Top module: `frame_pop_seq`

## Requirements
- R1: A start accepted with a frame count of zero ends on the next clock edge with `done_o` high and fault code GP (01). No validation request is issued and there is no commit.
- R2: The frame address is `ssa_ofs_i + enc_base_i + 4096 * frame_pages_i * (cssa_i - 1)`, and it is the address of the first validation request.
- R3: The number of frame pages is ceil(`xsave_bytes_i` / 4096), with a minimum of 1. The pages are requested in ascending order at frame + 4096*k. A request holds its address until it is acknowledged. Page k's physical address is committed to slot k of `xsave_pa_o` (slot k in bits k*PW upward), unused slots read 0, and the page count appears on `xsave_npages_o`.
- R4: After the frame pages, the address frame + 4096 * `frame_pages_i` - GPR_BYTES is validated. On commit, `gpr_pa_o` is the returned page number joined with that address's low 12 bits.
- R5: When `mode64_i` is 0 and the last byte of the register area (frame + 4096*`frame_pages_i` - 1) exceeds `ds_limit_i`, the operation ends with GP and `fault_addr_o` equal to the register-area address. An area that ends exactly at the limit passes. When `mode64_i` is 1, the limit has no effect.
- R6: The control-flow save page is requested, with `val_shadow_o` high, only when `cet_present_i` is 1 and at least one of `shstk_en_i` or `ibt_en_i` is 1. Its area address is `cet_ofs_i + enc_base_i + 16*(cssa_i - 1)`, and the page requested is that address with its low 12 bits cleared. On commit, `cet_pa_o` is the page number joined with the area's low 12 bits, and `cet_pa_vld_o` shows whether the check ran.
- R7: On success, `done_o` is high with fault code NONE (00). In the same cycle `cssa_we_o` is high and `cssa_new_o` equals the snapshot count minus 1.
- R8: A failed validation ends the operation on the acknowledge edge with fault code PF (10) and `fault_addr_o` equal to the address requested. No further request is made, and `gpr_pa_o`, `xsave_pa_o` and `cet_pa_o` keep their previous values.
- R9: A frame that needs more pages than MAX_PAGES ends on the next edge with PF and `fault_addr_o` equal to the frame address, and no request is made. Exactly MAX_PAGES pages are accepted.
- R10: `busy_o` is high from the edge that accepts a start until the edge that raises `done_o`. `done_o` lasts one cycle. A start while busy is ignored. After reset, `busy_o`, `done_o`, `val_req_o` and all committed outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin one pop operation |
| cssa_i | input | CW | Current frame count |
| enc_base_i | input | AW | Enclave base linear address |
| ssa_ofs_i | input | AW | Offset of the save-frame stack |
| cet_ofs_i | input | AW | Offset of the control-flow save slots |
| frame_pages_i | input | FW | Frame size in 4 KiB pages |
| xsave_bytes_i | input | XW | Extended-state save size in bytes |
| mode64_i | input | 1 | 64-bit mode, which disables the segment check |
| ds_limit_i | input | AW | Data-segment limit (last valid address) |
| cet_present_i | input | 1 | Control-flow protection feature present |
| shstk_en_i | input | 1 | Shadow-stack enable attribute |
| ibt_en_i | input | 1 | Branch-tracking enable attribute |
| val_req_o | output | 1 | Page validation request |
| val_addr_o | output | AW | Linear address to validate |
| val_shadow_o | output | 1 | Request expects a shadow-save page type |
| val_ack_i | input | 1 | Validation answer strobe |
| val_ok_i | input | 1 | Validation passed |
| val_ppn_i | input | PW-12 | Physical page number of the validated page |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end of operation |
| fault_o | output | 2 | 00 none, 01 GP, 10 PF |
| fault_addr_o | output | AW | Faulting linear address (0 when none) |
| cssa_we_o | output | 1 | Write strobe for the lowered count |
| cssa_new_o | output | CW | Lowered frame count |
| gpr_pa_o | output | PW | Committed register-area physical address |
| xsave_pa_o | output | MAX_PAGES*PW | Committed frame page physical addresses |
| xsave_npages_o | output | XW-11 | Committed frame page count |
| cet_pa_o | output | PW | Committed control-flow save physical address |
| cet_pa_vld_o | output | 1 | Control-flow save address was part of the commit |

## Verification
Early exits (zero count, too many pages) show `done_o` one edge after the start edge, so the bench samples at the first falling edge after releasing start. A walk lasts two cycles per request with the bench's responder, and the total depends on the page count. The bench therefore polls `done_o` at falling edges and samples the fault, commit strobe and committed addresses in that same cycle, because all of them are registered on the done edge. It checks the following falling edge for the drop of `done_o`. The responder logs every requested address and its shadow flag, so that order, count and the absence of requests after a fault are compared against values worked out from the address formulas.

// File: rtl/frame_pop_seq.sv
module frame_pop_seq #(
  parameter int AW        = 32,
  parameter int PW        = 32,
  parameter int CW        = 8,
  parameter int FW        = 8,
  parameter int XW        = 16,
  parameter int MAX_PAGES = 4,
  parameter int GPR_BYTES = 184
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [CW-1:0]           cssa_i,
  input  logic [AW-1:0]           enc_base_i,
  input  logic [AW-1:0]           ssa_ofs_i,
  input  logic [AW-1:0]           cet_ofs_i,
  input  logic [FW-1:0]           frame_pages_i,
  input  logic [XW-1:0]           xsave_bytes_i,
  input  logic                    mode64_i,
  input  logic [AW-1:0]           ds_limit_i,
  input  logic                    cet_present_i,
  input  logic                    shstk_en_i,
  input  logic                    ibt_en_i,
  output logic                    val_req_o,
  output logic [AW-1:0]           val_addr_o,
  output logic                    val_shadow_o,
  input  logic                    val_ack_i,
  input  logic                    val_ok_i,
  input  logic [PW-13:0]          val_ppn_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [1:0]              fault_o,
  output logic [AW-1:0]           fault_addr_o,
  output logic                    cssa_we_o,
  output logic [CW-1:0]           cssa_new_o,
  output logic [PW-1:0]           gpr_pa_o,
  output logic [MAX_PAGES*PW-1:0] xsave_pa_o,
  output logic [XW-12:0]          xsave_npages_o,
  output logic [PW-1:0]           cet_pa_o,
  output logic                    cet_pa_vld_o
);

  localparam int IW = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1;
  localparam int NW = XW - 11;
  localparam int MW = CW + FW;
  localparam logic [1:0] F_NONE = 2'd0;
  localparam logic [1:0] F_GP   = 2'd1;
  localparam logic [1:0] F_PF   = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_GPR, S_CET} st_t;

  st_t            st;
  logic [IW-1:0]  idx;
  logic [NW-1:0]  npg_q;
  logic [AW-1:0]  frame_q, gpr_q, gend_q, cet_q, dslim_q;
  logic [CW-1:0]  cssa_q;
  logic           mode64_q, cet_on_q;
  logic [PW-1:0]  tmp_q [MAX_PAGES];
  logic [PW-1:0]  gtmp_q;

  wire [CW-1:0] cssa_m1 = cssa_i - 1'b1;
  wire [MW-1:0] fidx    = MW'(cssa_m1) * MW'(frame_pages_i);
  wire [AW-1:0] frame_a = ssa_ofs_i + enc_base_i + AW'({fidx, 12'h000});
  wire [AW-1:0] fsize   = AW'({frame_pages_i, 12'h000});
  wire [AW-1:0] cet_a   = cet_ofs_i + enc_base_i + AW'({cssa_m1, 4'h0});
  wire [XW:0]   xs_sum  = {1'b0, xsave_bytes_i} + (XW+1)'(4095);
  wire [NW-1:0] np_raw  = NW'(xs_sum >> 12);
  wire [NW-1:0] np      = (np_raw == '0) ? NW'(1) : np_raw;
  wire          too_many = 32'(np) > MAX_PAGES;

  wire accept   = (st == S_IDLE) && start_i;
  wire ack_ok   = val_ack_i && val_ok_i;
  wire seg_bad  = !mode64_q && (gend_q > dslim_q);
  wire last_pg  = (32'(idx) + 1) == 32'(npg_q);
  wire [PW-1:0] pa_now = {val_ppn_i, val_addr_o[11:0]};

  wire gp_now = (accept && cssa_i == '0) ||
                (st == S_GPR && ack_ok && seg_bad);
  wire pf_now = (accept && cssa_i != '0 && too_many) ||
                (st != S_IDLE && val_ack_i && !val_ok_i);
  wire commit = (st == S_GPR && ack_ok && !seg_bad && !cet_on_q) ||
                (st == S_CET && ack_ok);

  logic [AW-1:0] faddr;
  always_comb begin
    if (st == S_IDLE)     faddr = (cssa_i == '0) ? '0 : frame_a;
    else if (st == S_GPR && val_ok_i) faddr = gpr_q;
    else                  faddr = val_addr_o;
  end

  assign busy_o       = st != S_IDLE;
  assign val_req_o    = st != S_IDLE;
  assign val_shadow_o = st == S_CET;

  always_comb begin
    case (st)
      S_WALK:  val_addr_o = frame_q + AW'({idx, 12'h000});
      S_GPR:   val_addr_o = gpr_q;
      S_CET:   val_addr_o = {cet_q[AW-1:12], 12'h000};
      default: val_addr_o = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      npg_q    <= '0;
      frame_q  <= '0;
      gpr_q    <= '0;
      gend_q   <= '0;
      cet_q    <= '0;
      dslim_q  <= '0;
      cssa_q   <= '0;
      mode64_q <= 1'b0;
      cet_on_q <= 1'b0;
      gtmp_q   <= '0;
      for (int i = 0; i < MAX_PAGES; i++) tmp_q[i] <= '0;
      done_o       <= 1'b0;
      fault_o      <= F_NONE;
      fault_addr_o <= '0;
    end else begin
      done_o       <= gp_now || pf_now || commit;
      fault_o      <= gp_now ? F_GP : (pf_now ? F_PF : F_NONE);
      fault_addr_o <= (gp_now || pf_now) ? faddr : '0;
      case (st)
        S_IDLE: if (start_i) begin
          frame_q  <= frame_a;
          gpr_q    <= frame_a + fsize - AW'(GPR_BYTES);
          gend_q   <= frame_a + fsize - AW'(1);
          cet_q    <= cet_a;
          dslim_q  <= ds_limit_i;
          cssa_q   <= cssa_i;
          mode64_q <= mode64_i;
          cet_on_q <= cet_present_i && (shstk_en_i || ibt_en_i);
          npg_q    <= np;
          idx      <= '0;
          if (cssa_i != '0 && !too_many) st <= S_WALK;
        end
        S_WALK: if (val_ack_i) begin
          if (!val_ok_i) st <= S_IDLE;
          else begin
            tmp_q[idx] <= pa_now;
            if (last_pg) st <= S_GPR;
            else idx <= idx + 1'b1;
          end
        end
        S_GPR: if (val_ack_i) begin
          gtmp_q <= pa_now;
          if (!val_ok_i || seg_bad || !cet_on_q) st <= S_IDLE;
          else st <= S_CET;
        end
        S_CET: if (val_ack_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cssa_we_o      <= 1'b0;
      cssa_new_o     <= '0;
      gpr_pa_o       <= '0;
      xsave_pa_o     <= '0;
      xsave_npages_o <= '0;
      cet_pa_o       <= '0;
      cet_pa_vld_o   <= 1'b0;
    end else begin
      cssa_we_o <= commit;
      if (commit) begin
        cssa_new_o     <= cssa_q - 1'b1;
        gpr_pa_o       <= (st == S_GPR) ? pa_now : gtmp_q;
        xsave_npages_o <= npg_q;
        cet_pa_vld_o   <= cet_on_q;
        for (int i = 0; i < MAX_PAGES; i++)
          xsave_pa_o[i*PW +: PW] <= (i < int'(npg_q)) ? tmp_q[i] : '0;
        if (st == S_CET) cet_pa_o <= {val_ppn_i, cet_q[11:0]};
      end
    end
  end

  p_zero_gp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && cssa_i == '0) |=> (done_o && fault_o == F_GP && !cssa_we_o));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (val_req_o && !val_ack_i) |=> (val_req_o && $stable(val_addr_o)));

  p_shadow_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (val_req_o && val_shadow_o) |-> cet_on_q);

  p_commit_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cssa_we_o |-> (done_o && fault_o == F_NONE));

  p_fault_nocommit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_o != F_NONE) |-> !cssa_we_o);

  p_pa_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cssa_we_o |-> ($stable(gpr_pa_o) && $stable(xsave_pa_o) && $stable(cet_pa_o)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: tb/frame_pop_seq_tb_top.sv
module frame_pop_seq_tb_top;
  localparam logic [31:0] PAO = 32'h4000_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start_i, mode64_i, cet_present_i, shstk_en_i, ibt_en_i;
  logic [7:0]  cssa_i, frame_pages_i;
  logic [31:0] enc_base_i, ssa_ofs_i, cet_ofs_i, ds_limit_i;
  logic [15:0] xsave_bytes_i;
  logic        val_req_o, val_shadow_o, val_ack_i, val_ok_i;
  logic [31:0] val_addr_o;
  logic [19:0] val_ppn_i;
  logic        busy_o, done_o, cssa_we_o, cet_pa_vld_o;
  logic [1:0]  fault_o;
  logic [31:0] fault_addr_o, gpr_pa_o, cet_pa_o;
  logic [7:0]  cssa_new_o;
  logic [127:0] xsave_pa_o;
  logic [4:0]  xsave_npages_o;

  frame_pop_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cssa_i(cssa_i),
    .enc_base_i(enc_base_i), .ssa_ofs_i(ssa_ofs_i), .cet_ofs_i(cet_ofs_i),
    .frame_pages_i(frame_pages_i), .xsave_bytes_i(xsave_bytes_i),
    .mode64_i(mode64_i), .ds_limit_i(ds_limit_i), .cet_present_i(cet_present_i),
    .shstk_en_i(shstk_en_i), .ibt_en_i(ibt_en_i), .val_req_o(val_req_o),
    .val_addr_o(val_addr_o), .val_shadow_o(val_shadow_o), .val_ack_i(val_ack_i),
    .val_ok_i(val_ok_i), .val_ppn_i(val_ppn_i), .busy_o(busy_o), .done_o(done_o),
    .fault_o(fault_o), .fault_addr_o(fault_addr_o), .cssa_we_o(cssa_we_o),
    .cssa_new_o(cssa_new_o), .gpr_pa_o(gpr_pa_o), .xsave_pa_o(xsave_pa_o),
    .xsave_npages_o(xsave_npages_o), .cet_pa_o(cet_pa_o), .cet_pa_vld_o(cet_pa_vld_o)
  );

  int nchk = 0, nfail = 0, nreq = 0;
  logic [31:0] rq_addr [16];
  logic        rq_sh [16];
  logic        bad_en = 1'b0;
  logic [31:0] bad_addr = '0;
  logic [1:0]  c_fault;
  logic [31:0] c_faddr;
  logic        c_we;
  logic [7:0]  c_new;
  int          c_cyc;

  task automatic ceq(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    val_ack_i = 1'b0; val_ok_i = 1'b0; val_ppn_i = '0;
    forever begin
      @(negedge clk);
      if (val_ack_i) val_ack_i = 1'b0;
      else if (val_req_o) begin
        val_ack_i = 1'b1;
        val_ok_i  = !(bad_en && val_addr_o == bad_addr);
        val_ppn_i = 20'((val_addr_o + PAO) >> 12);
        if (nreq < 16) begin
          rq_addr[nreq] = val_addr_o;
          rq_sh[nreq]   = val_shadow_o;
        end
        nreq++;
      end
    end
  end

  task automatic cfg(input logic [7:0] c, input logic [31:0] base, so, co,
                     input logic [7:0] fp, input logic [15:0] xs, input logic m64,
                     input logic [31:0] lim, input logic cp, sh, ib);
    cssa_i = c; enc_base_i = base; ssa_ofs_i = so; cet_ofs_i = co;
    frame_pages_i = fp; xsave_bytes_i = xs; mode64_i = m64; ds_limit_i = lim;
    cet_present_i = cp; shstk_en_i = sh; ibt_en_i = ib;
  endtask

  task automatic launch();
    nreq = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    c_cyc = 1;
    while (!done_o && c_cyc < 500) begin @(negedge clk); c_cyc++; end
    c_fault = fault_o; c_faddr = fault_addr_o; c_we = cssa_we_o; c_new = cssa_new_o;
    @(negedge clk);
    ceq("R10 done lasts one cycle", done_o, 0);
  endtask

  task automatic t_reset();
    ceq("R10 busy after reset", busy_o, 0);
    ceq("R10 done after reset", done_o, 0);
    ceq("R10 req after reset", val_req_o, 0);
    ceq("R10 gpr_pa after reset", gpr_pa_o, 0);
  endtask

  task automatic t_zero();
    cfg(0, 32'h1000_0000, 32'h2000, 0, 2, 5000, 1, 0, 0, 0, 0);
    launch();
    ceq("R1 done one edge after start", c_cyc, 1);
    ceq("R1 fault GP", c_fault, 1);
    ceq("R1 no requests", nreq, 0);
    ceq("R1 no commit", c_we, 0);
  endtask

  task automatic t_basic();
    cfg(3, 32'h1000_0000, 32'h2000, 0, 2, 5000, 1, 0, 0, 0, 0);
    launch();
    ceq("R7 fault none", c_fault, 0);
    ceq("R7 commit strobe", c_we, 1);
    ceq("R7 new count", c_new, 2);
    ceq("R3 request count", nreq, 3);
    ceq("R2 first request frame addr", rq_addr[0], 32'h1000_6000);
    ceq("R3 second page addr", rq_addr[1], 32'h1000_7000);
    ceq("R4 gpr request addr", rq_addr[2], 32'h1000_7F48);
    ceq("R3 slot0", xsave_pa_o[31:0], 32'h5000_6000);
    ceq("R3 slot1", xsave_pa_o[63:32], 32'h5000_7000);
    ceq("R3 unused slots zero", xsave_pa_o[127:64], 0);
    ceq("R3 page count", xsave_npages_o, 2);
    ceq("R4 gpr_pa", gpr_pa_o, 32'h5000_7F48);
    ceq("R6 no cet when disabled", cet_pa_vld_o, 0);
  endtask

  task automatic t_min_page();
    cfg(1, 32'h0, 32'h3000, 0, 1, 0, 1, 0, 0, 0, 0);
    launch();
    ceq("R3 zero size gives one page", xsave_npages_o, 1);
    ceq("R2 frame addr count one", rq_addr[0], 32'h3000);
    ceq("R4 gpr addr one-page frame", rq_addr[1], 32'h3F48);
    ceq("R7 new count zero", c_new, 0);
  endtask

  task automatic t_cet(input logic sh, input logic ib);
    cfg(2, 32'h2000_0000, 32'h1000, 32'h5008, 1, 100, 1, 0, 1, sh, ib);
    launch();
    ceq("R6 request count with cet", nreq, 3);
    ceq("R6 cet page addr", rq_addr[2], 32'h2000_5000);
    ceq("R6 cet shadow flag", rq_sh[2], 1);
    ceq("R6 frame req not shadow", rq_sh[0], 0);
    ceq("R6 cet_pa", cet_pa_o, 32'h6000_5018);
    ceq("R6 cet valid", cet_pa_vld_o, 1);
    ceq("R7 commit with cet", c_we, 1);
  endtask

  task automatic t_cet_gated(input logic cp, input logic sh, input logic ib);
    cfg(2, 32'h2000_0000, 32'h1000, 32'h5008, 1, 100, 1, 0, cp, sh, ib);
    launch();
    ceq("R6 gated request count", nreq, 2);
    ceq("R6 gated cet valid", cet_pa_vld_o, 0);
  endtask

  task automatic t_pf_walk();
    logic [31:0] g0;
    logic [127:0] x0;
    cfg(3, 32'h1000_0000, 32'h2000, 0, 2, 5000, 1, 0, 0, 0, 0);
    g0 = gpr_pa_o; x0 = xsave_pa_o;
    bad_en = 1'b1; bad_addr = 32'h1000_7000;
    launch();
    bad_en = 1'b0;
    ceq("R8 walk fault PF", c_fault, 2);
    ceq("R8 walk fault addr", c_faddr, 32'h1000_7000);
    ceq("R8 no request after fault", nreq, 2);
    ceq("R8 no commit", c_we, 0);
    ceq("R8 gpr_pa unchanged", gpr_pa_o, g0);
    ceq("R8 xsave_pa unchanged", xsave_pa_o, x0);
  endtask

  task automatic t_pf_cet();
    logic [31:0] c0;
    cfg(2, 32'h2000_0000, 32'h1000, 32'h5008, 1, 100, 1, 0, 1, 1, 0);
    c0 = cet_pa_o;
    bad_en = 1'b1; bad_addr = 32'h2000_5000;
    launch();
    bad_en = 1'b0;
    ceq("R8 cet fault PF", c_fault, 2);
    ceq("R8 cet fault addr", c_faddr, 32'h2000_5000);
    ceq("R8 cet_pa unchanged", cet_pa_o, c0);
    ceq("R8 cet fault no commit", c_we, 0);
  endtask

  task automatic t_seg();
    cfg(3, 32'h1000_0000, 32'h2000, 0, 2, 5000, 0, 32'h1000_7FFE, 0, 0, 0);
    launch();
    ceq("R5 segment GP", c_fault, 1);
    ceq("R5 segment fault addr", c_faddr, 32'h1000_7F48);
    ceq("R5 segment no commit", c_we, 0);
    cfg(3, 32'h1000_0000, 32'h2000, 0, 2, 5000, 0, 32'h1000_7FFF, 0, 0, 0);
    launch();
    ceq("R5 end at limit passes", c_fault, 0);
    cfg(3, 32'h1000_0000, 32'h2000, 0, 2, 5000, 1, 32'h0, 0, 0, 0);
    launch();
    ceq("R5 limit ignored in 64-bit", c_we, 1);
  endtask

  task automatic t_depth();
    cfg(1, 32'h3000_0000, 32'h0, 0, 4, 16385, 1, 0, 0, 0, 0);
    launch();
    ceq("R9 oversize PF", c_fault, 2);
    ceq("R9 oversize addr", c_faddr, 32'h3000_0000);
    ceq("R9 oversize no requests", nreq, 0);
    ceq("R9 oversize done next edge", c_cyc, 1);
    cfg(1, 32'h3000_0000, 32'h0, 0, 4, 16384, 1, 0, 0, 0, 0);
    launch();
    ceq("R9 full depth commits", c_we, 1);
    ceq("R9 full depth pages", xsave_npages_o, 4);
    ceq("R9 full depth slot3", xsave_pa_o[127:96], 32'h7000_3000);
    ceq("R9 full depth requests", nreq, 5);
  endtask

  task automatic t_busy();
    cfg(3, 32'h1000_0000, 32'h2000, 0, 2, 5000, 1, 0, 0, 0, 0);
    nreq = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    ceq("R10 busy after start", busy_o, 1);
    cssa_i = 0; start_i = 1'b1;
    @(negedge clk) start_i = 1'b0; cssa_i = 3;
    c_cyc = 2;
    while (!done_o && c_cyc < 500) begin @(negedge clk); c_cyc++; end
    ceq("R10 start while busy ignored", fault_o, 0);
    ceq("R10 commit value intact", cssa_new_o, 2);
    ceq("R10 busy low at done", busy_o, 0);
    @(negedge clk);
    ceq("R10 no second operation", busy_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0;
    cfg(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_zero();
    t_basic();
    t_min_page();
    t_cet(1, 0);
    t_cet(0, 1);
    t_cet_gated(0, 1, 1);
    t_cet_gated(1, 0, 0);
    t_pf_walk();
    t_pf_cet();
    t_seg();
    t_depth();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule